// File: doc/BRIEF.md
# Fetch Address Generator with Tagged Branch Target Cache

This block produces the fetch address of an in-order pipeline. It holds the program counter and a small direct-mapped cache of branch targets. In every cycle the current address looks itself up in the cache. The low address bits select one entry, and the remaining high bits must equal the tag stored in that entry. If the entry matches and its single direction bit says taken, the next fetch address is the stored target. In all other cases the address steps forward by one instruction.

The execute stage writes back each resolved branch through an update port. The write carries the branch address, the actual direction and the destination, and it replaces whatever the selected entry held before. When execute finds a wrong prediction, it drives a redirect that loads the correct address. The redirect wins over every other source. A fetch enable lets the pipeline freeze the address while it stalls. Instruction memory and pipeline flushing sit outside this block.

Top module: `btc_fetch_unit`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `fetch_pc` equals RESET_VEC (default 0x0000). Every cache entry starts invalid, so `pred_hit` is 0 at every address until an update has been written.
- R2: Entry selection uses address bits [3:0] and the tag is address bits [15:4]. `pred_hit` is 1 only when the selected entry has been written and its stored tag equals bits [15:4] of `fetch_pc`. An address with the same index but a different tag misses.
- R3: `pred_taken` is 1 exactly when `pred_hit` is 1 and the matching entry's direction bit is 1 (1 = taken, 0 = not taken).
- R4: With `fetch_en` high, no redirect and `pred_taken` high, `fetch_pc` takes the stored target of the matching entry at the next clock.
- R5: With `fetch_en` high, no redirect and `pred_taken` low, `fetch_pc` increases by one at the next clock, modulo 2^16 (0xFFFF is followed by 0x0000).
- R6: With `fetch_en` low and no redirect, `fetch_pc` keeps its value.
- R7: When `redir_valid` is high, `fetch_pc` takes `redir_pc` at the next clock, whatever the values of `fetch_en` and the prediction.
- R8: When `upd_valid` is high at a clock edge, the entry indexed by `upd_pc[3:0]` becomes valid. It stores tag `upd_pc[15:4]`, target `upd_target` and direction bit `upd_taken`, and it replaces the previous contents of that entry.
- R9: A lookup in the same cycle as an update to the looked-up entry sees the old contents. The new contents are visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en | input | 1 | Allows the fetch address to advance |
| redir_valid | input | 1 | Load the correction address at the next clock |
| redir_pc | input | 16 | Correction address from execute |
| upd_valid | input | 1 | Write a resolved branch into the cache |
| upd_pc | input | 16 | Address of the resolved branch |
| upd_taken | input | 1 | Actual branch direction, 1 = taken |
| upd_target | input | 16 | Resolved branch destination |
| fetch_pc | output | 16 | Current fetch address |
| pred_hit | output | 1 | Current address matches a valid entry |
| pred_taken | output | 1 | Current address is predicted as a taken branch |

## Verification
On every cycle the assertions check the choice of the next address. They check that a redirect is loaded, that a stalled address holds, that the address steps by one when no taken prediction exists, that the cache target is followed on a taken prediction, and that a taken prediction never occurs without a hit. Only the bench's scenarios can show the contents of the cache. These include tag aliasing on a shared index, overwriting by later updates, the old-contents rule for a lookup during a write, the empty cache after reset and the wrap from 0xFFFF to 0x0000. The bench's reference model tracks these, and the scenarios drive them on purpose.

// File: rtl/btc_pkg.sv
package btc_pkg;

    typedef enum logic [1:0] {
        NPC_HOLD  = 2'd0,
        NPC_SEQ   = 2'd1,
        NPC_TGT   = 2'd2,
        NPC_REDIR = 2'd3
    } npc_sel_e;

endpackage

// File: rtl/btc_array.sv
module btc_array #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_pc,
    output logic              rd_hit,
    output logic              rd_taken,
    output logic [ADDR_W-1:0] rd_target,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic              wr_taken,
    input  logic [ADDR_W-1:0] wr_target
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] target;
        logic              taken;
    } entry_t;

    entry_t [DEPTH-1:0] tbl_d, tbl_q;

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    logic [DEPTH-1:0] match;

    assign rd_idx = rd_pc[IDX_W-1:0];
    assign rd_tag = rd_pc[ADDR_W-1:IDX_W];
    assign wr_idx = wr_pc[IDX_W-1:0];
    assign wr_tag = wr_pc[ADDR_W-1:IDX_W];

    // Per-entry tag comparators; the index then picks one result.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = tbl_q[i].valid && (tbl_q[i].tag == rd_tag);
    end

    assign rd_hit    = match[rd_idx];
    assign rd_taken  = match[rd_idx] && tbl_q[rd_idx].taken;
    assign rd_target = tbl_q[rd_idx].target;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx].valid  = 1'b1;
            tbl_d[wr_idx].tag    = wr_tag;
            tbl_d[wr_idx].target = wr_target;
            tbl_d[wr_idx].taken  = wr_taken;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

endmodule

// File: rtl/btc_next_pc.sv
module btc_next_pc
    import btc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int STEP   = 1
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              adv_en,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_pc,
    input  logic              pred_taken,
    input  logic [ADDR_W-1:0] pred_target,
    output logic [ADDR_W-1:0] next_pc
);
    npc_sel_e sel;

    always_comb begin
        if (redir_valid) begin
            sel = NPC_REDIR;
        end else if (!adv_en) begin
            sel = NPC_HOLD;
        end else if (pred_taken) begin
            sel = NPC_TGT;
        end else begin
            sel = NPC_SEQ;
        end

        unique case (sel)
            NPC_REDIR: next_pc = redir_pc;
            NPC_TGT:   next_pc = pred_target;
            NPC_SEQ:   next_pc = cur_pc + ADDR_W'(STEP);
            default:   next_pc = cur_pc;
        endcase
    end

endmodule

// File: rtl/btc_fetch_unit.sv
module btc_fetch_unit #(
    parameter int          ADDR_W    = 16,
    parameter int          IDX_W     = 4,
    parameter int          STEP      = 1,
    parameter logic [15:0] RESET_VEC = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic              pred_taken
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] pred_tgt;
    logic [ADDR_W-1:0] npc;

    btc_array #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pc     (st_q.pc),
        .rd_hit    (pred_hit),
        .rd_taken  (pred_taken),
        .rd_target (pred_tgt),
        .wr_en     (upd_valid),
        .wr_pc     (upd_pc),
        .wr_taken  (upd_taken),
        .wr_target (upd_target)
    );

    btc_next_pc #(
        .ADDR_W (ADDR_W),
        .STEP   (STEP)
    ) u_next (
        .cur_pc      (st_q.pc),
        .adv_en      (fetch_en),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .pred_taken  (pred_taken),
        .pred_target (pred_tgt),
        .next_pc     (npc)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = npc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc <= ADDR_W'(RESET_VEC);
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc = st_q.pc;

endmodule

// File: rtl/btc_fetch_unit_chk.sv
module btc_fetch_unit_chk #(
    parameter int          ADDR_W    = 16,
    parameter int          STEP      = 1,
    parameter logic [15:0] RESET_VEC = 16'h0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_en,
    input logic              redir_valid,
    input logic [ADDR_W-1:0] redir_pc,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_tgt
);
    // R1: first cycle out of reset presents the reset vector
    a_r1_reset_vector: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) === 1'b0 |-> fetch_pc == ADDR_W'(RESET_VEC));

    // R3: a taken prediction needs a tag hit
    a_r3_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);

    // R4: taken prediction steers fetch to the cached target
    a_r4_follow_target: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en && !redir_valid && pred_taken |=> fetch_pc == $past(pred_tgt));

    // R5: sequential step without a taken prediction
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en && !redir_valid && !pred_taken
        |=> fetch_pc == ADDR_W'($past(fetch_pc) + ADDR_W'(STEP)));

    // R6: stalled fetch holds its address
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en && !redir_valid |=> $stable(fetch_pc));

    // R7: redirect wins over all other sources
    a_r7_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> fetch_pc == $past(redir_pc));

endmodule

bind btc_fetch_unit btc_fetch_unit_chk #(
    .ADDR_W    (ADDR_W),
    .STEP      (STEP),
    .RESET_VEC (RESET_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_en    (fetch_en),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .fetch_pc    (fetch_pc),
    .pred_hit    (pred_hit),
    .pred_taken  (pred_taken),
    .pred_tgt    (pred_tgt)
);

// File: tb/btc_fetch_unit_test.sv
`timescale 1ns/1ps
module btc_fetch_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_en = 1'b0;
    logic        redir_valid = 1'b0;
    logic [15:0] redir_pc = '0;
    logic        upd_valid = 1'b0;
    logic [15:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [15:0] upd_target = '0;
    logic [15:0] fetch_pc;
    logic        pred_hit;
    logic        pred_taken;

    always #4 clk = ~clk;

    btc_fetch_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_en    (fetch_en),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .upd_valid   (upd_valid),
        .upd_pc      (upd_pc),
        .upd_taken   (upd_taken),
        .upd_target  (upd_target),
        .fetch_pc    (fetch_pc),
        .pred_hit    (pred_hit),
        .pred_taken  (pred_taken)
    );

    // Behavioural reference: a plain address counter and a 16-slot table.
    int m_pc;
    bit m_vld [16];
    int m_tag [16];
    int m_tgt [16];
    bit m_dir [16];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    function automatic bit m_hit();
        int i = m_pc % 16;
        return m_vld[i] && (m_tag[i] == m_pc / 16);
    endfunction

    function automatic bit m_take();
        return m_hit() && m_dir[m_pc % 16];
    endfunction

    task automatic check(input string req);
        n_checks++;
        if (int'(fetch_pc) != m_pc) begin
            n_fail++;
            $display("FAIL %s fetch_pc actual=%h expected=%h", req, fetch_pc, m_pc[15:0]);
        end
        n_checks++;
        if (pred_hit != m_hit()) begin
            n_fail++;
            $display("FAIL %s pred_hit actual=%0d expected=%0d at pc=%h", req, pred_hit, m_hit(), fetch_pc);
        end
        n_checks++;
        if (pred_taken != m_take()) begin
            n_fail++;
            $display("FAIL %s pred_taken actual=%0d expected=%0d at pc=%h", req, pred_taken, m_take(), fetch_pc);
        end
    endtask

    // One clock: inputs are already set; the model advances with the design.
    task automatic cyc(input string req);
        bit tk;
        int nxt;
        @(posedge clk);
        tk = m_take();
        if (redir_valid)   nxt = int'(redir_pc);
        else if (!fetch_en) nxt = m_pc;
        else if (tk)       nxt = m_tgt[m_pc % 16];
        else               nxt = (m_pc + 1) % 65536;
        if (upd_valid) begin
            m_vld[int'(upd_pc) % 16] = 1'b1;
            m_tag[int'(upd_pc) % 16] = int'(upd_pc) / 16;
            m_tgt[int'(upd_pc) % 16] = int'(upd_target);
            m_dir[int'(upd_pc) % 16] = upd_taken;
        end
        m_pc = nxt;
        @(negedge clk);
        check(req);
    endtask

    task automatic idle();
        redir_valid = 1'b0;
        upd_valid   = 1'b0;
    endtask

    task automatic go_to(input logic [15:0] a, input string req);
        redir_valid = 1'b1;
        redir_pc    = a;
        cyc(req);
        redir_valid = 1'b0;
    endtask

    task automatic learn(input logic [15:0] a, input bit t, input logic [15:0] d, input string req);
        upd_valid  = 1'b1;
        upd_pc     = a;
        upd_taken  = t;
        upd_target = d;
        cyc(req);
        upd_valid  = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = 0; m_tgt[i] = 0; m_dir[i] = 1'b0;
        end
        m_pc = 0;
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        check("R1 after release");

        // R1: empty cache, sequential fetch across all indices
        fetch_en = 1'b1;
        repeat (20) cyc("R1 empty cache R5 step");

        // R8 + R4: learn a taken branch at 0x0005, then reach it
        fetch_en = 1'b0;
        learn(16'h0005, 1'b1, 16'h0100, "R8 write taken");
        go_to(16'h0003, "R7 redirect");
        fetch_en = 1'b1;
        repeat (4) cyc("R4 follow target");

        // R2: same index, different tag misses
        go_to(16'h0015, "R7 redirect");
        repeat (3) cyc("R2 alias miss");

        // R3: not-taken entry hits but steps by one
        learn(16'h0101, 1'b0, 16'h0200, "R8 write not taken");
        go_to(16'h0100, "R7 redirect");
        repeat (3) cyc("R3 hit not taken");

        // R8: overwrite the not-taken entry as taken
        learn(16'h0101, 1'b1, 16'h0400, "R8 overwrite");
        go_to(16'h0101, "R7 redirect");
        repeat (2) cyc("R8 overwritten entry R4");

        // R6: stall holds the address
        fetch_en = 1'b0;
        repeat (4) cyc("R6 hold");

        // R7: redirect while stalled, and while a taken prediction is present
        go_to(16'h0777, "R7 redirect stalled");
        go_to(16'h0005, "R7 setup");
        fetch_en = 1'b1;
        go_to(16'h0AB0, "R7 over prediction");

        // R9: update to the looked-up entry during a stall
        fetch_en = 1'b0;
        go_to(16'h0030, "R7 setup");
        learn(16'h0030, 1'b1, 16'h0050, "R9 old contents same cycle");
        cyc("R9 new contents next cycle");
        fetch_en = 1'b1;
        cyc("R9 R4 use new entry");

        // R5: wrap at the top of the address space
        go_to(16'hFFFE, "R7 setup");
        repeat (3) cyc("R5 wrap");

        // Mixed traffic
        for (int k = 0; k < 400; k++) begin
            fetch_en    = ($urandom % 4) != 0;
            redir_valid = ($urandom % 10) == 0;
            redir_pc    = 16'($urandom % 64);
            upd_valid   = ($urandom % 3) == 0;
            upd_pc      = 16'(m_pc + int'($urandom % 6));
            upd_taken   = 1'($urandom);
            upd_target  = 16'($urandom % 80);
            cyc("R2 R8 mixed traffic");
        end
        idle();
        cyc("R2 mixed final");

        finish_run();
    end

endmodule